// File: doc/BRIEF.md
# Accumulator Shift and Rotate Unit

This block is the single-bit shift and rotate datapath of an 8-bit accumulator-style processor. It takes an operand byte, a 2-bit operation code and the current status byte. It returns the shifted or rotated byte together with a new status byte. In the new status byte only the negative, zero and carry bits are rewritten. The unit is purely combinational, so its results are valid in the same cycle as its inputs. The instruction sequencer registers them wherever its pipeline needs.

The two rotates take their fill bit from the incoming carry. Every operation writes the bit that leaves the byte back into carry. A small decoder is built alongside the datapath. It recognises the four accumulator-form opcodes of this instruction family and turns them into the operation code, which saves the sequencer a separate lookup.

The block holds no state, so there is no state machine, no state register and no transition in it. Its three leaf modules are the opcode decoder, the shift core and the status merge.

Top module: `shift_rotate_unit`

## Requirements
- R1: With op_sel_i = 0 (shift left), result_o is the operand moved one place toward bit 7 with bit 0 cleared, and the carry bit (status bit 0) takes operand bit 7. Examples: 0x55 gives 0xAA with carry 0, and 0xAA gives 0x54 with carry 1.
- R2: With op_sel_i = 1 (rotate left), result_o[7:1] is operand[6:0] and result_o[0] is the incoming carry (stat_i bit 0). The new carry is operand bit 7. Example: 0x55 with carry 1 gives 0xAB.
- R3: With op_sel_i = 2 (logical shift right), result_o is the operand moved one place toward bit 0 with bit 7 cleared, and carry takes operand bit 0. As a result the negative bit is always 0. Example: 0x55 gives 0x2A with carry 1.
- R4: With op_sel_i = 3 (rotate right), result_o[6:0] is operand[7:1] and result_o[7] is the incoming carry. The new carry is operand bit 0. Examples: 0x55 with carry 1 gives 0xAA with carry 1, and 0xAA with carry 0 gives 0x55 with carry 0.
- R5: Status bit 7 (negative) of stat_o equals result_o bit 7.
- R6: Status bit 1 (zero) of stat_o is 1 exactly when result_o equals 0x00.
- R7: Status bits 6 down to 2 of stat_o equal the same bits of stat_i for every operation. Examples with stat_i = 0xFF and operand 0x55: shift left gives stat_o = 0xFC, logical shift right gives 0x7D and rotate right gives 0xFD. With stat_i = 0x00, shift left of 0xAA gives 0x01 and logical shift right of 0xAA gives 0x00.
- R8: The decoder drives dec_hit_o = 1 and the following dec_op_o for the four accumulator opcodes: 0x0A gives 0, 0x2A gives 1, 0x4A gives 2 and 0x6A gives 3. For every other opcode it drives dec_hit_o = 0 and dec_op_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte to be shifted or rotated |
| op_sel_i | input | 2 | Operation: 0 shift left, 1 rotate left, 2 logical shift right, 3 rotate right |
| stat_i | input | 8 | Incoming status byte; bit 0 is the carry used as fill by the rotates |
| result_o | output | 8 | Shifted or rotated byte |
| stat_o | output | 8 | Status byte with bits 7, 1 and 0 rewritten and the rest copied from stat_i |
| opcode_i | input | 8 | Instruction opcode presented to the decoder |
| dec_op_o | output | 2 | Operation code decoded from opcode_i |
| dec_hit_o | output | 1 | High when opcode_i is one of the four accumulator opcodes |

## Verification
The checker assumes that every input is a settled, known binary value whenever its combinational checks evaluate. Any X or Z on op_sel_i or stat_i would leave the expected fill and carry bits undefined. The bench drives all inputs only at rising edges and holds them for the whole cycle. The scoreboard compares outputs at the falling edge, once the logic has settled. The stimulus covers only defined values: every operand byte with both carry values and all four operation codes. The status bits that must pass through unchanged are toggled by XOR-ing the operand with a varying pattern. The opcode input runs through all 256 codes so that both decoder hits and misses are covered.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned OPW    = 2;

    // Flag positions inside the status byte; a neighbour decodes them.
    localparam int unsigned FLAG_N = 7;
    localparam int unsigned FLAG_Z = 1;
    localparam int unsigned FLAG_C = 0;

    typedef enum logic [OPW-1:0] {
        OP_SHL = 2'd0,
        OP_ROL = 2'd1,
        OP_SHR = 2'd2,
        OP_ROR = 2'd3
    } shift_op_e;

    // Accumulator-form opcode pattern: 0 ss 01010, ss selects the operation.
    localparam logic [4:0] ACC_LOW_PATTERN = 5'b01010;

endpackage

// File: rtl/sr_opcode_decode.sv
module sr_opcode_decode
    import shift_rotate_pkg::*;
(
    input  logic [DATA_W-1:0] opcode_i,
    output shift_op_e         op_o,
    output logic              hit_o
);

    logic low_match;
    logic top_clear;

    always_comb begin
        low_match = (opcode_i[4:0] == ACC_LOW_PATTERN);
        top_clear = (opcode_i[DATA_W-1] == 1'b0);
        hit_o     = low_match && top_clear;
        if (hit_o) begin
            op_o = shift_op_e'(opcode_i[6:5]);
        end else begin
            op_o = OP_SHL;
        end
    end

endmodule

// File: rtl/sr_shift_core.sv
module sr_shift_core
    import shift_rotate_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] opnd_i,
    input  shift_op_e    op_i,
    input  logic         carry_i,
    output logic [W-1:0] result_o,
    output logic         carry_o
);

    localparam int unsigned MSB = W - 1;

    logic [W-1:0] left_path;
    logic [W-1:0] right_path;
    logic         left_fill;
    logic         right_fill;

    always_comb begin
        left_fill  = (op_i == OP_ROL) ? carry_i : 1'b0;
        right_fill = (op_i == OP_ROR) ? carry_i : 1'b0;
    end

    // Bit-wise neighbour wiring for both directions.
    for (genvar b = 0; b < W; b++) begin : g_bits
        if (b == 0) begin : g_lsb
            assign left_path[b] = left_fill;
        end else begin : g_lmid
            assign left_path[b] = opnd_i[b-1];
        end
        if (b == MSB) begin : g_msb
            assign right_path[b] = right_fill;
        end else begin : g_rmid
            assign right_path[b] = opnd_i[b+1];
        end
    end

    always_comb begin
        unique case (op_i)
            OP_SHL, OP_ROL: begin
                result_o = left_path;
                carry_o  = opnd_i[MSB];
            end
            OP_SHR, OP_ROR: begin
                result_o = right_path;
                carry_o  = opnd_i[0];
            end
            default: begin
                result_o = '0;
                carry_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sr_flag_merge.sv
module sr_flag_merge
    import shift_rotate_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] stat_i,
    input  logic [W-1:0] result_i,
    input  logic         carry_i,
    output logic [W-1:0] stat_o
);

    always_comb begin
        stat_o         = stat_i;
        stat_o[FLAG_N] = result_i[W-1];
        stat_o[FLAG_Z] = (result_i == '0);
        stat_o[FLAG_C] = carry_i;
    end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import shift_rotate_pkg::*;
(
    input  logic [7:0] opnd_i,
    input  logic [1:0] op_sel_i,
    input  logic [7:0] stat_i,
    output logic [7:0] result_o,
    output logic [7:0] stat_o,
    input  logic [7:0] opcode_i,
    output logic [1:0] dec_op_o,
    output logic       dec_hit_o
);

    shift_op_e    op_q;
    shift_op_e    dec_op;
    logic         carry_out;
    logic [DATA_W-1:0] core_res;

    assign op_q = shift_op_e'(op_sel_i);

    sr_opcode_decode u_decode (
        .opcode_i (opcode_i),
        .op_o     (dec_op),
        .hit_o    (dec_hit_o)
    );

    sr_shift_core #(.W(DATA_W)) u_core (
        .opnd_i   (opnd_i),
        .op_i     (op_q),
        .carry_i  (stat_i[FLAG_C]),
        .result_o (core_res),
        .carry_o  (carry_out)
    );

    sr_flag_merge #(.W(DATA_W)) u_flags (
        .stat_i   (stat_i),
        .result_i (core_res),
        .carry_i  (carry_out),
        .stat_o   (stat_o)
    );

    assign result_o = core_res;
    assign dec_op_o = dec_op;

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk (
    input logic [7:0] opnd_i,
    input logic [1:0] op_sel_i,
    input logic [7:0] stat_i,
    input logic [7:0] result_o,
    input logic [7:0] stat_o,
    input logic [7:0] opcode_i,
    input logic [1:0] dec_op_o,
    input logic       dec_hit_o
);

    always_comb begin
        if (!$isunknown({opnd_i, op_sel_i, stat_i})) begin
            // R1
            shl_carry_chk: assert (op_sel_i != 2'd0 || stat_o[0] == opnd_i[7]);
            // R2
            rol_fill_chk: assert (op_sel_i != 2'd1 || result_o[0] == stat_i[0]);
            // R3
            shr_neg_chk: assert (op_sel_i != 2'd2 || stat_o[7] == 1'b0);
            // R4
            ror_fill_chk: assert (op_sel_i != 2'd3 || result_o[7] == stat_i[0]);
            // R5
            neg_flag_chk: assert (stat_o[7] == result_o[7]);
            // R6
            zero_flag_chk: assert (stat_o[1] == (result_o == 8'h00));
            // R7
            keep_bits_chk: assert (stat_o[6:2] == stat_i[6:2]);
        end
        if (!$isunknown(opcode_i)) begin
            // R8
            dec_miss_chk: assert (dec_hit_o || dec_op_o == 2'd0);
        end
    end

endmodule

bind shift_rotate_unit shift_rotate_unit_chk u_chk (.*);

// File: tb/shift_rotate_unit_bench.sv
module shift_rotate_unit_bench;

    typedef struct {
        logic [7:0] res;
        logic [7:0] stat;
        logic [1:0] dop;
        logic       dhit;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       done = 1'b0;
    logic [7:0] opnd = '0;
    logic [1:0] sel = '0;
    logic [7:0] stat = '0;
    logic [7:0] opcode = '0;
    logic [7:0] res;
    logic [7:0] stat_out;
    logic [1:0] dop;
    logic       dhit;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    shift_rotate_unit u_shift_rotate_unit (
        .opnd_i    (opnd),
        .op_sel_i  (sel),
        .stat_i    (stat),
        .result_o  (res),
        .stat_o    (stat_out),
        .opcode_i  (opcode),
        .dec_op_o  (dop),
        .dec_hit_o (dhit)
    );

    function automatic exp_t model(logic [7:0] a, logic [1:0] s, logic [7:0] st,
                                   logic [7:0] oc, string tag);
        exp_t e;
        logic c;
        case (s)
            2'd0: begin e.res = {a[6:0], 1'b0};  c = a[7]; end
            2'd1: begin e.res = {a[6:0], st[0]}; c = a[7]; end
            2'd2: begin e.res = {1'b0, a[7:1]};  c = a[0]; end
            default: begin e.res = {st[0], a[7:1]}; c = a[0]; end
        endcase
        e.stat = {e.res[7], st[6:2], (e.res == 8'h00), c};
        case (oc)
            8'h0A: begin e.dhit = 1'b1; e.dop = 2'd0; end
            8'h2A: begin e.dhit = 1'b1; e.dop = 2'd1; end
            8'h4A: begin e.dhit = 1'b1; e.dop = 2'd2; end
            8'h6A: begin e.dhit = 1'b1; e.dop = 2'd3; end
            default: begin e.dhit = 1'b0; e.dop = 2'd0; end
        endcase
        e.tag = tag;
        return e;
    endfunction

    function automatic string op_tag(logic [1:0] s);
        case (s)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic drive(logic [7:0] a, logic [1:0] s, logic [7:0] st,
                         logic [7:0] oc, string tag);
        @(posedge clk);
        opnd = a; sel = s; stat = st; opcode = oc;
        sb.push_back(model(a, s, st, oc, tag));
    endtask

    task automatic cmp8(string tag, string what, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare settled outputs at the falling edge.
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp8(e.tag, "result", res, e.res);
            cmp8({e.tag, "/R5/R6/R7"}, "status", stat_out, e.stat);
            cmp8("R8", "dec_op", {6'd0, dop}, {6'd0, e.dop});
            cmp8("R8", "dec_hit", {7'd0, dhit}, {7'd0, e.dhit});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // reset state: all-zero inputs, shift left of zero sets zero flag
        cmp8("R6", "reset result", res, 8'h00);
        cmp8("R6", "reset status", stat_out, 8'h02);
        rst_n = 1'b1;

        // directed corner values
        drive(8'h55, 2'd0, 8'hFF, 8'h0A, "R1_R7");
        drive(8'hAA, 2'd0, 8'h00, 8'h2A, "R1");
        drive(8'h55, 2'd1, 8'hFF, 8'h4A, "R2");
        drive(8'h55, 2'd1, 8'h01, 8'h6A, "R2");
        drive(8'h55, 2'd2, 8'hFF, 8'h4B, "R3_R7");
        drive(8'hAA, 2'd2, 8'h00, 8'hCA, "R3");
        drive(8'h01, 2'd2, 8'h00, 8'h8A, "R3_R6");
        drive(8'h55, 2'd3, 8'hFF, 8'h0B, "R4_R7");
        drive(8'hAA, 2'd3, 8'h00, 8'h1A, "R4");
        drive(8'h80, 2'd0, 8'h7C, 8'hEA, "R1_R6");

        // full sweep
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a < 256; a++) begin
                    logic [7:0] st;
                    st = 8'(a) ^ 8'(s * 37 + c * 91);
                    st[0] = c[0];
                    drive(8'(a), 2'(s), st, 8'(a), op_tag(2'(s)));
                end
            end
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule